// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

This block turns a single-cycle timestamp-compare hit into timed output pulses. A hit that the block accepts starts a primary pulse, optionally after a programmable start delay. The primary pulse has a programmable width counted in clock cycles. A secondary output follows each primary pulse after its own delay and has the same width.

A period of zero selects one-shot mode: each accepted hit produces exactly one pulse. This is the usual way to get a once-per-second output aligned to a timebase, with software re-arming the compare after every hit. A nonzero period makes the block re-fire on its own every period cycles until it is switched off.

The registers are loaded through a simple write port. Two sticky flags record that each output has begun a pulse. Clearing the global enable stops all activity at once.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset both outputs and both flags are low.
- R2: With start delay 0, a hit accepted at clock edge t drives `sync0_out` high after edge t for max(W,1) cycles, where W is the width register at address 1.
- R3: When the period register (address 2) is 0, each accepted hit yields exactly one primary pulse.
- R4: When the period P is nonzero (and larger than the width), primary pulses begin every P cycles after the first one until the global enable is cleared.
- R5: A start delay D (address 3) moves the first primary pulse to edge t+D.
- R6: A secondary pulse of the same width begins D1 cycles after every primary pulse start, where D1 is at address 4.
- R7: The control register at address 0 holds three enables. Bit 0 is the global enable: with it low, hits are ignored. Bit 1 gates `sync0_out` and bit 2 gates `sync1_out`.
- R8: A control write with bit 0 low forces both outputs low right after that write edge and cancels any pending delay or repetition.
- R9: A hit that arrives while a pulse, a start delay or a repetition is in progress is ignored.
- R10: Flag bit 0 (`sync0_flag`) sets when a primary pulse begins with bit 1 enabled. Flag bit 1 (`sync1_flag`) sets when a secondary pulse begins with bit 2 enabled. Writing 1 to the matching bit at address 5 clears a flag; if a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 width, 2 period, 3 start delay, 4 secondary delay, 5 flag clear) |
| wr_data | input | CW | Write data |
| cmp_hit | input | 1 | Compare-match trigger, one cycle wide |
| sync0_out | output | 1 | Primary pulse output |
| sync1_out | output | 1 | Secondary pulse output |
| sync0_flag | output | 1 | Sticky flag: a primary pulse has begun |
| sync1_flag | output | 1 | Sticky flag: a secondary pulse has begun |

## Verification
The assertions watch properties that must hold on every cycle:
- a disable write or a cleared enable leaves nothing running;
- a busy hit never reloads the width count;
- flags stay set until cleared and set whenever an enabled pulse begins.

Exact pulse placement can only be shown by the bench scenarios. Those scenarios cover width, start delay, period spacing and the secondary offset. The bench sweeps widths, delays, periods and secondary offsets, and compares every cycle against a waveform computed arithmetically.

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          cmp_hit,
  output logic          sync0_out,
  output logic          sync1_out,
  output logic          sync0_flag,
  output logic          sync1_flag
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_WID  = 3'd1;
  localparam logic [2:0] A_PER  = 3'd2;
  localparam logic [2:0] A_SDLY = 3'd3;
  localparam logic [2:0] A_D1   = 3'd4;
  localparam logic [2:0] A_FLAG = 3'd5;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [2:0]    ctrl_q;
  logic [CW-1:0] wid_q, per_q, sdly_q, d1_q;
  logic [1:0]    flag_q;

  logic          arm0, p0, rep, arm1, p1;
  logic [CW-1:0] c0, w0, pc, c1, w1;

  logic kill, busy, take, fire0, fire1;
  logic [CW-1:0] wlast;

  assign kill  = !ctrl_q[0] || (wr_en && wr_addr == A_CTRL && !wr_data[0]);
  assign busy  = p0 || arm0 || rep;
  assign take  = cmp_hit && ctrl_q[0] && !busy;
  assign fire0 = (take && sdly_q == ZERO) || (arm0 && c0 == ZERO) || (rep && pc == ZERO);
  assign fire1 = (fire0 && d1_q == ZERO) || (arm1 && c1 == ZERO);
  assign wlast = (wid_q == ZERO) ? ZERO : wid_q - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wid_q  <= '0;
      per_q  <= '0;
      sdly_q <= '0;
      d1_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q <= wr_data[2:0];
        A_WID:   wid_q  <= wr_data;
        A_PER:   per_q  <= wr_data;
        A_SDLY:  sdly_q <= wr_data;
        A_D1:    d1_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      arm0 <= 1'b0; c0 <= '0;
      p0   <= 1'b0; w0 <= '0;
      rep  <= 1'b0; pc <= '0;
      arm1 <= 1'b0; c1 <= '0;
      p1   <= 1'b0; w1 <= '0;
    end else begin
      if (take && sdly_q != ZERO) begin
        arm0 <= 1'b1;
        c0   <= sdly_q - ONE;
      end else if (arm0) begin
        if (c0 == ZERO) arm0 <= 1'b0;
        else            c0   <= c0 - ONE;
      end

      if (fire0) begin
        p0 <= 1'b1;
        w0 <= wlast;
      end else if (p0) begin
        if (w0 == ZERO) p0 <= 1'b0;
        else            w0 <= w0 - ONE;
      end

      if (fire0 && per_q != ZERO) begin
        rep <= 1'b1;
        pc  <= per_q - ONE;
      end else if (rep) begin
        pc <= pc - ONE;
      end

      if (fire0 && d1_q != ZERO) begin
        arm1 <= 1'b1;
        c1   <= d1_q - ONE;
      end else if (arm1) begin
        if (c1 == ZERO) arm1 <= 1'b0;
        else            c1   <= c1 - ONE;
      end

      if (fire1) begin
        p1 <= 1'b1;
        w1 <= wlast;
      end else if (p1) begin
        if (w1 == ZERO) p1 <= 1'b0;
        else            w1 <= w1 - ONE;
      end
    end
  end

  logic [1:0] clr;
  assign clr = (wr_en && wr_addr == A_FLAG) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else begin
      flag_q[0] <= (flag_q[0] && !clr[0]) || (fire0 && ctrl_q[1] && !kill);
      flag_q[1] <= (flag_q[1] && !clr[1]) || (fire1 && ctrl_q[2] && !kill);
    end
  end

  assign sync0_out  = p0 && ctrl_q[0] && ctrl_q[1];
  assign sync1_out  = p1 && ctrl_q[0] && ctrl_q[2];
  assign sync0_flag = flag_q[0];
  assign sync1_flag = flag_q[1];
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          cmp_hit,
  input logic [2:0]    ctrl,
  input logic          p0,
  input logic          arm0,
  input logic          rep,
  input logic [CW-1:0] w0,
  input logic          fire0,
  input logic [1:0]    flag,
  input logic          sync0_out,
  input logic          sync1_out
);
  logic off_wr, clr0;
  assign off_wr = wr_en && wr_addr == 3'd0 && !wr_data[0];
  assign clr0   = wr_en && wr_addr == 3'd5 && wr_data[0];

  AST_OFF_WRITE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    off_wr |=> (!sync0_out && !sync1_out && !p0 && !arm0 && !rep)); // R8

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !(wr_en && wr_addr == 3'd0)) |=> (!p0 && !arm0 && !rep)); // R7

  AST_BUSY_HIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (p0 && cmp_hit && !rep && !arm0 && ctrl[0] && !off_wr) |=> (!p0 || w0 == $past(w0) - 1)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !clr0) |=> flag[0]); // R10

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && ctrl[0] && ctrl[1] && !off_wr) |=> flag[0]); // R10
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmp_hit(cmp_hit), .ctrl(ctrl_q), .p0(p0), .arm0(arm0), .rep(rep), .w0(w0),
  .fire0(fire0), .flag(flag_q), .sync0_out(sync0_out), .sync1_out(sync1_out)
);

// File: tb/sync_pulse_gen_tb.sv
`timescale 1ns/1ps
module sync_pulse_gen_tb;
  localparam int CW = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, cmp_hit = 0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic s0, s1, f0, f1;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sync_pulse_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_hit(cmp_hit), .sync0_out(s0), .sync1_out(s1), .sync0_flag(f0), .sync1_flag(f1)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic hit;
    @(negedge clk);
    cmp_hit = 1;
    @(negedge clk);
    cmp_hit = 0;
  endtask

  function automatic logic expw(int k, int d, int w, int p);
    int we;
    we = (w == 0) ? 1 : w;
    if (k < d) return 1'b0;
    if (p == 0) return (k - d) < we;
    return ((k - d) % p) < we;
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wl[4] = '{0, 1, 2, 3};
    int dl[3] = '{0, 1, 3};
    int pl[3] = '{0, 5, 7};
    int ql[2] = '{0, 2};
    int rises;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s0, 0, "R1 sync0"); chk(s1, 0, "R1 sync1");
    chk(f0, 0, "R1 flag0"); chk(f1, 0, "R1 flag1");

    foreach (wl[i]) foreach (dl[j]) foreach (pl[m]) foreach (ql[n]) begin
      wr(0, 0);
      wr(1, wl[i]); wr(2, pl[m]); wr(3, dl[j]); wr(4, ql[n]);
      wr(5, 3);
      wr(0, 7);
      hit();
      for (int k = 0; k < 30; k++) begin
        chk(s0, expw(k, dl[j], wl[i], pl[m]), "R2 R3 R4 R5 sync0 shape");
        chk(s1, expw(k, dl[j] + ql[n], wl[i], pl[m]), "R6 sync1 shape");
        @(negedge clk);
      end
      chk(f0, 1, "R10 flag0 set"); chk(f1, 1, "R10 flag1 set");
      if (pl[m] != 0) begin
        wr(0, 0);
        for (int k = 0; k < 10; k++) begin
          chk(s0, 0, "R8 sync0 after off"); chk(s1, 0, "R8 sync1 after off");
          @(negedge clk);
        end
      end
      wr(5, 3);
      chk(f0, 0, "R10 flag0 clear"); chk(f1, 0, "R10 flag1 clear");
    end

    // R9: second hit during an active pulse is ignored
    wr(0, 0); wr(1, 4); wr(2, 0); wr(3, 0); wr(4, 0); wr(0, 3);
    rises = 0; prev = 0;
    hit();
    for (int k = 0; k < 20; k++) begin
      if (k == 2) cmp_hit = 1;
      if (k == 3) cmp_hit = 0;
      if (s0 && !prev) rises++;
      prev = s0;
      @(negedge clk);
    end
    chk(rises == 1, 1, "R9 single pulse despite busy hit");
    hit();
    chk(s0, 1, "R9 hit accepted after pulse ends");

    // R7: sync1 disabled stays low, flag1 stays clear
    wr(0, 0); wr(5, 3); wr(1, 2); wr(4, 1); wr(0, 3);
    hit();
    for (int k = 0; k < 6; k++) begin
      chk(s1, 0, "R7 sync1 gated");
      @(negedge clk);
    end
    chk(f1, 0, "R7 flag1 not set while gated");
    chk(f0, 1, "R7 flag0 set while enabled");

    // R7: global enable low ignores hits
    wr(0, 6); wr(5, 3);
    hit();
    for (int k = 0; k < 6; k++) begin
      chk(s0, 0, "R7 no sync0 when global off");
      chk(s1, 0, "R7 no sync1 when global off");
      @(negedge clk);
    end
    chk(f0, 0, "R7 no flag when global off");

    // R8: disable mid-pulse drops output at once
    wr(0, 0); wr(1, 8); wr(2, 0); wr(3, 0); wr(0, 3);
    hit();
    chk(s0, 1, "R8 pulse running");
    wr(0, 2);
    chk(s0, 0, "R8 dropped right after off write");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule